// File: doc/BRIEF.md
# 32-Pin GPIO Bank with Atomic Set/Clear

A bank of general-purpose pins behind a small memory-mapped register port. Software selects each pin's direction, drives an output value through a data latch and reads the level on the pads. The output latch can be written whole. Two alias addresses change only the bits flagged in the written mask, so two software agents can update separate pins without a read-modify-write race.

The pad side gives one output value, one output enable and one input level per pin. Pad inputs pass through a two-flop synchronizer before software can read them. For this reason a read shortly after a pad change, including a change caused by the bank's own output, returns the old level for up to two cycles. The input register shows every pad, whatever its direction.

The port takes a byte address. The two low address bits are ignored. Reads are combinational from the address, and writes take effect at the clock edge on which `we_i` is high.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After an asynchronous reset, every direction bit is 1 (all pins are inputs), the output latch is 0, `pad_oe_o` is 0 and the input register reads 0.
- R2: Offset 0x00 is the direction register. It is written and read as a whole word. A bit of 1 makes the pin an input (`pad_oe_o` bit = 0), and a bit of 0 makes it an output (`pad_oe_o` bit = 1). The change appears on the cycle after the write edge.
- R3: Offset 0x04 is the output latch. It is written directly and read back, and `pad_out_o` equals the latch.
- R4: A write to offset 0x08 sets the latch bits where the mask is 1 and leaves all other bits unchanged.
- R5: A write to offset 0x0C clears the latch bits where the mask is 1 and leaves all other bits unchanged.
- R6: Reads of offsets 0x08 and 0x0C return the output latch.
- R7: Offset 0x10 returns each pad level two clock edges after it is applied, and still the old level after only one edge. This holds for pins set as outputs too.
- R8: Writes to offset 0x10 and to offsets 0x14 through 0x3C change no state. Reads of 0x14 through 0x3C return 0.
- R9: When `we_i` is low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bank clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data or mask |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pad_in_i | input | 32 | Pad input levels, asynchronous |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables, 1 = drive |

## Verification
The bench gives set and clear masks that overlap bits already high or low. A design that rewrote the whole latch, or inverted the mask polarity, would disturb pins outside the mask. It also writes the input register and unused offsets, and raises the write data with the strobe low. A decoder that aliased those addresses onto the latch, or ignored `we_i`, would corrupt the outputs. The bench checks the input path one edge and two edges after a pad change, with every pin set as an output. A synchronizer that was too short or too long would show the new level one edge early or too late. A design that masked output pins would read 0 instead of the pad.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  // word indices of the register map (byte offset = index * 4)
  localparam int unsigned IDX_DIR = 0;
  localparam int unsigned IDX_OUT = 1;
  localparam int unsigned IDX_SET = 2;
  localparam int unsigned IDX_CLR = 3;
  localparam int unsigned IDX_IN  = 4;
endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[i]};
    end
    assign sync_o[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
  import pin_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] dir_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (we_i) begin
      if (idx_i == IDX_W'(IDX_DIR)) dir_q <= wdata_i;
      if (idx_i == IDX_W'(IDX_OUT)) out_q <= wdata_i;
      if (idx_i == IDX_W'(IDX_SET)) out_q <= out_q | wdata_i;
      if (idx_i == IDX_W'(IDX_CLR)) out_q <= out_q & ~wdata_i;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
endmodule

// File: rtl/pin_bank_rdmux.sv
module pin_bank_rdmux
  import pin_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] out_i,
  input  logic [WIDTH-1:0] in_i,
  output logic [WIDTH-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (idx_i == IDX_W'(IDX_DIR)) rdata_o = dir_i;
    if (idx_i == IDX_W'(IDX_OUT) || idx_i == IDX_W'(IDX_SET) ||
        idx_i == IDX_W'(IDX_CLR)) rdata_o = out_i;
    if (idx_i == IDX_W'(IDX_IN))  rdata_o = in_i;
  end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl #(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_oe_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_lsb;
  logic [WIDTH-1:0] dir, out, in_sync;

  assign idx        = addr_i[ADDR_W-1:2];
  assign unused_lsb = addr_i[1:0];

  pin_bank_regs #(.WIDTH(WIDTH), .IDX_W(IDX_W)) i_regs (
    .clk_i, .rst_ni, .we_i, .idx_i(idx), .wdata_i,
    .dir_o(dir), .out_o(out)
  );

  pin_bank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .async_i(pad_in_i), .sync_o(in_sync)
  );

  pin_bank_rdmux #(.WIDTH(WIDTH), .IDX_W(IDX_W)) i_rdmux (
    .idx_i(idx), .dir_i(dir), .out_i(out), .in_i(in_sync), .rdata_o
  );

  assign pad_out_o = out;
  assign pad_oe_o  = ~dir;
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pad_in_i,
  input logic [WIDTH-1:0]  pad_out_o,
  input logic [WIDTH-1:0]  pad_oe_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  logic [1:0] live_q;
  assign idx = addr_i[ADDR_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          live_q <= '0;
    else if (live_q != 3) live_q <= live_q + 2'd1;
  end

  // R2: direction write drives inverted enables
  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == IDX_W'(0)) |=> pad_oe_o == ~$past(wdata_i));
  // R3: direct latch write
  a_r3_out_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == IDX_W'(1)) |=> pad_out_o == $past(wdata_i));
  // R4: set alias
  a_r4_set_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == IDX_W'(2)) |=> pad_out_o == ($past(pad_out_o) | $past(wdata_i)));
  // R5: clear alias
  a_r5_clr_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == IDX_W'(3)) |=> pad_out_o == ($past(pad_out_o) & ~$past(wdata_i)));
  // R6: alias reads return latch
  a_r6_alias_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == IDX_W'(2) || idx == IDX_W'(3)) |-> rdata_o == pad_out_o);
  // R8: unused offsets and input register writes change nothing
  a_r8_no_side_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx >= IDX_W'(4)) |=> ($stable(pad_out_o) && $stable(pad_oe_o)));
  // R9: no write strobe, no change
  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pad_out_o) && $stable(pad_oe_o)));

  if (SYNC_STAGES == 2) begin : g_lat
    // R7: two-edge input latency
    a_r7_in_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q >= 2 && idx == IDX_W'(4)) |-> rdata_o == $past(pad_in_i, 2));
  end
endmodule

bind pin_bank_ctrl pin_bank_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) i_chk (.*);

// File: tb/test_pin_bank_ctrl.sv
`timescale 1ns/100ps
module test_pin_bank_ctrl;
  logic        clk_i = 0, rst_ni = 0, we_i = 0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, pad_in_i = '0;
  logic [31:0] rdata_o, pad_out_o, pad_oe_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pin_bank_ctrl i_pin_bank_ctrl (.*);

  task automatic check(input string tag, input logic [31:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input string tag, input logic [31:0] exp);
    addr_i = a;
    #0.2;
    check(tag, rdata_o, exp);
  endtask

  // {req, we, addr, wdata, exp_out, exp_oe}
  localparam int NV = 12;
  localparam logic [106:0] VEC [NV] = '{
    {4'd2, 1'b1, 6'h00, 32'h0000FFFF, 32'h00000000, 32'hFFFF0000}, // R2
    {4'd3, 1'b1, 6'h04, 32'h12345678, 32'h12345678, 32'hFFFF0000}, // R3
    {4'd4, 1'b1, 6'h08, 32'h80000001, 32'h92345679, 32'hFFFF0000}, // R4
    {4'd5, 1'b1, 6'h0C, 32'h00000078, 32'h92345601, 32'hFFFF0000}, // R5
    {4'd4, 1'b1, 6'h08, 32'h00000000, 32'h92345601, 32'hFFFF0000}, // R4 empty mask
    {4'd5, 1'b1, 6'h0C, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0000}, // R5 full mask
    {4'd8, 1'b1, 6'h10, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0000}, // R8 input reg
    {4'd8, 1'b1, 6'h14, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0000}, // R8 unused
    {4'd9, 1'b0, 6'h04, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0000}, // R9
    {4'd8, 1'b1, 6'h3C, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0000}, // R8 top offset
    {4'd3, 1'b1, 6'h06, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'hFFFF0000}, // R3 low bits ignored
    {4'd2, 1'b1, 6'h00, 32'h00000000, 32'hA5A5A5A5, 32'hFFFFFFFF}  // R2 all outputs
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #5;
    // R1 reset state
    check("R1 oe", pad_oe_o, 32'h0);
    check("R1 out", pad_out_o, 32'h0);
    rd(6'h00, "R1 dir", 32'hFFFFFFFF);
    rd(6'h10, "R1 in", 32'h0);
    @(negedge clk_i); rst_ni = 1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      we_i = VEC[k][102]; addr_i = VEC[k][101:96]; wdata_i = VEC[k][95:64];
      @(negedge clk_i);
      we_i = 0; wdata_i = '0;
      check($sformatf("R%0d vec%0d out", VEC[k][106:103], k), pad_out_o, VEC[k][63:32]);
      check($sformatf("R%0d vec%0d oe", VEC[k][106:103], k), pad_oe_o, VEC[k][31:0]);
      rd(6'h00, $sformatf("R2 vec%0d dir", k), ~VEC[k][31:0]);
      rd(6'h04, $sformatf("R3 vec%0d latch", k), VEC[k][63:32]);
      rd(6'h08, $sformatf("R6 vec%0d set-read", k), VEC[k][63:32]);
      rd(6'h0C, $sformatf("R6 vec%0d clr-read", k), VEC[k][63:32]);
    end

    // R8 unused reads return zero
    rd(6'h14, "R8 rd 0x14", 32'h0);
    rd(6'h3C, "R8 rd 0x3C", 32'h0);

    // R7 sync latency with all pins as outputs
    addr_i = 6'h10;
    @(negedge clk_i); pad_in_i = 32'hDEADBEEF;
    @(negedge clk_i); rd(6'h10, "R7 one edge", 32'h0);
    @(negedge clk_i); rd(6'h10, "R7 two edges", 32'hDEADBEEF);
    pad_in_i = 32'h0F0F0F0F;
    @(negedge clk_i); rd(6'h10, "R7 hold old", 32'hDEADBEEF);
    @(negedge clk_i); rd(6'h10, "R7 new", 32'h0F0F0F0F);

    // R1 reset mid-run
    rst_ni = 0;
    #0.5;
    check("R1 rerst out", pad_out_o, 32'h0);
    check("R1 rerst oe", pad_oe_o, 32'h0);
    rd(6'h10, "R1 rerst in", 32'h0);
    @(negedge clk_i); rst_ni = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule